// File: doc/BRIEF.md
# Descriptor Fetch Queue Error Tracker

This block is the pointer queue and error register of one crypto-engine channel. Software writes descriptor pointers into a small queue. The channel takes them out one at a time when it is ready to fetch. Alongside the queue, the block keeps five sticky error flags. Software clears each flag by writing a 1 to it. Any flag that is set drives an error interrupt.

Overflow of the queue escalates in two stages. A first write to the full queue drops the pointer and leaves the channel running. A second such write, made while the first flag is still set, halts the channel. A bus error reported by the master side also halts it. A halted channel stops handing out pointers but still accepts new ones while there is room. It restarts only on a continue command or a channel reset. The block also keeps registered copies of the reset-done and done lines of the primary and secondary execution units.

Top module: `dfq_err_tracker`

## Requirements
- R1: After `rst` (synchronous, active high) `status` is 0, `err_irq` is 0, `halted` is 0 and `pop_valid` is 0.
- R2: Accepted pointers leave on `pop_ptr` in the order they were written. A pop takes place on an edge where `pop_valid` and `pop_ready` are both 1. The queue holds DEPTH entries (default 4).
- R3: A nonzero write to the full queue with no pop on the same edge sets `status[0]` (first overflow) and drops the pointer. It does not halt the channel.
- R4: An overflow while `status[0]` is already set also sets `status[1]` (second overflow) and sets `halted`.
- R5: A write to the full queue on the same edge as a pop is stored normally and sets no flag.
- R6: When `clr_valid` is 1, each bit of `clr_mask` that is 1 clears the matching flag in `status[4:0]`. A 0 bit leaves its flag unchanged. A flag being set on the same edge wins over the clear.
- R7: `bus_err` sets `status[2]` and sets `halted`.
- R8: A write of an all-zero pointer sets `status[3]`, is not stored, and does not halt the channel.
- R9: `sg_check_valid` with an all-zero `sg_value` sets `status[4]`. A nonzero value sets nothing.
- R10: `err_irq` is 1 exactly when any of `status[4:0]` is 1, in the same cycle.
- R11: While `halted` is 1, `pop_valid` is 0 and no pop happens, but writes are still stored while there is room.
- R12: `ctl_continue` clears `halted`. It leaves the queue contents and the flags unchanged.
- R13: `ctl_reset` empties the queue and clears all flags and `halted`. Any other events on that edge are dropped.
- R14: `status[5]`, `status[6]`, `status[7]` and `status[8]` show `pri_rst_done`, `sec_rst_done`, `pri_done` and `sec_done` as they were one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous engine reset, active high |
| push_valid | input | 1 | Write a descriptor pointer |
| push_ptr | input | PTR_W | Pointer being written |
| pop_ready | input | 1 | Channel takes the head pointer |
| pop_valid | output | 1 | Head pointer available and channel not halted |
| pop_ptr | output | PTR_W | Head pointer |
| sg_check_valid | input | 1 | A scatter/gather pointer or length is presented |
| sg_value | input | PTR_W | Scatter/gather value checked for zero |
| bus_err | input | 1 | Master bus transfer error |
| ctl_continue | input | 1 | Continue command |
| ctl_reset | input | 1 | Channel reset command |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 5 | Flags to clear |
| pri_rst_done | input | 1 | Primary unit reset done |
| sec_rst_done | input | 1 | Secondary unit reset done |
| pri_done | input | 1 | Primary unit done |
| sec_done | input | 1 | Secondary unit done |
| status | output | 9 | Flags [4:0], unit mirrors [8:5] |
| err_irq | output | 1 | Error interrupt |
| halted | output | 1 | Channel halted |

## Verification
Three distinct pointer sequences go through the queue: a partial fill, a full fill, and a full queue written on the same edge as a pop. A scoreboard compares every pop. This tells order errors apart from dropped entries, and a legal full-with-pop write apart from an overflow. The two overflow stages are driven one after the other. This separates the dropped-pointer case from the halting case. A continue then shows that the stored entries survived the halt. Bus errors and zero pointers are raised on an empty queue. Writes made while halted show that storage keeps working while pops are blocked. A channel reset with entries pending shows that the queue is emptied.

// File: rtl/dfq_pkg.sv
package dfq_pkg;
  localparam int FLAG_N   = 5;
  localparam int MIRROR_N = 4;
  localparam int STAT_W   = FLAG_N + MIRROR_N;
  // flag positions inside status
  localparam int F_OVF1 = 0;
  localparam int F_OVF2 = 1;
  localparam int F_BUS  = 2;
  localparam int F_FZ   = 3;
  localparam int F_SGZ  = 4;
  typedef logic [FLAG_N-1:0] flags_t;
endpackage

// File: rtl/dfq_fifo.sv
module dfq_fifo #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [PTR_W-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [PTR_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_idx, rd_idx;
  logic [CW-1:0]    count;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_idx <= nxt(wr_idx);
      if (rd_en) rd_idx <= nxt(rd_idx);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_idx];
  assign empty   = (count == '0);
  assign full    = (count == CMAX);
endmodule

// File: rtl/dfq_err_ctrl.sv
module dfq_err_ctrl
  import dfq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ovf,
  input  logic   fetch_zero,
  input  logic   sg_zero,
  input  logic   bus_err,
  input  logic   cont,
  input  logic   creset,
  input  logic   clr_valid,
  input  flags_t clr_mask,
  output flags_t flags,
  output logic   halted,
  output logic   irq
);
  flags_t set_v, clr_v, flags_n;
  logic   halt_n;

  always_comb begin
    set_v         = '0;
    set_v[F_OVF1] = ovf;
    set_v[F_OVF2] = ovf && flags[F_OVF1];
    set_v[F_BUS]  = bus_err;
    set_v[F_FZ]   = fetch_zero;
    set_v[F_SGZ]  = sg_zero;
    clr_v         = clr_valid ? clr_mask : '0;
    if (creset) begin
      flags_n = '0;
      halt_n  = 1'b0;
    end else begin
      flags_n = (flags & ~clr_v) | set_v;
      if (set_v[F_OVF2] || set_v[F_BUS]) halt_n = 1'b1;
      else if (cont)                     halt_n = 1'b0;
      else                               halt_n = halted;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      halted <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flags  <= flags_n;
      halted <= halt_n;
      irq    <= |flags_n;
    end
  end
endmodule

// File: rtl/dfq_mirror.sv
module dfq_mirror #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/dfq_err_tracker.sv
module dfq_err_tracker
  import dfq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [PTR_W-1:0]  push_ptr,
  input  logic              pop_ready,
  output logic              pop_valid,
  output logic [PTR_W-1:0]  pop_ptr,
  input  logic              sg_check_valid,
  input  logic [PTR_W-1:0]  sg_value,
  input  logic              bus_err,
  input  logic              ctl_continue,
  input  logic              ctl_reset,
  input  logic              clr_valid,
  input  logic [FLAG_N-1:0] clr_mask,
  input  logic              pri_rst_done,
  input  logic              sec_rst_done,
  input  logic              pri_done,
  input  logic              sec_done,
  output logic [STAT_W-1:0] status,
  output logic              err_irq,
  output logic              halted
);
  logic   q_empty, q_full;
  logic   push_zero, pop_fire, push_ok, ovf, sg_zero;
  flags_t flags;
  logic [MIRROR_N-1:0] mirror_q;

  assign push_zero = push_valid && (push_ptr == '0);
  assign pop_fire  = pop_ready && !q_empty && !halted;
  assign push_ok   = push_valid && !push_zero && (!q_full || pop_fire);
  assign ovf       = push_valid && !push_zero && q_full && !pop_fire;
  assign sg_zero   = sg_check_valid && (sg_value == '0);

  dfq_fifo #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (ctl_reset),
    .wr_en   (push_ok && !ctl_reset),
    .wr_data (push_ptr),
    .rd_en   (pop_fire && !ctl_reset),
    .rd_data (pop_ptr),
    .empty   (q_empty),
    .full    (q_full)
  );

  dfq_err_ctrl u_err (
    .clk        (clk),
    .rst        (rst),
    .ovf        (ovf),
    .fetch_zero (push_zero),
    .sg_zero    (sg_zero),
    .bus_err    (bus_err),
    .cont       (ctl_continue),
    .creset     (ctl_reset),
    .clr_valid  (clr_valid),
    .clr_mask   (clr_mask),
    .flags      (flags),
    .halted     (halted),
    .irq        (err_irq)
  );

  dfq_mirror #(.N(MIRROR_N)) u_mirror (
    .clk (clk),
    .rst (rst),
    .d   ({sec_done, pri_done, sec_rst_done, pri_rst_done}),
    .q   (mirror_q)
  );

  assign status    = {mirror_q, flags};
  assign pop_valid = !q_empty && !halted;
endmodule

// File: rtl/dfq_err_tracker_chk.sv
module dfq_err_tracker_chk
  import dfq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_err,
  input logic              ctl_continue,
  input logic              ctl_reset,
  input logic              pri_rst_done,
  input logic              sec_done,
  input logic [STAT_W-1:0] status,
  input logic              err_irq,
  input logic              halted
);
  a_r10_irq_or: assert property (@(posedge clk) disable iff (rst)
    err_irq == (|status[FLAG_N-1:0]));

  a_r4_second_ovf_halts: assert property (@(posedge clk) disable iff (rst)
    $rose(status[F_OVF2]) |-> halted);

  a_r7_bus_err_halts: assert property (@(posedge clk) disable iff (rst)
    (bus_err && !ctl_reset) |=> (halted && status[F_BUS]));

  a_r12_halt_release: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> ($past(ctl_continue) || $past(ctl_reset) || $past(rst)));

  a_r13_chan_reset: assert property (@(posedge clk) disable iff (rst)
    ctl_reset |=> (status[FLAG_N-1:0] == '0 && !halted && !err_irq));

  a_r14_mirror: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (status[FLAG_N] == $past(pri_rst_done) && status[STAT_W-1] == $past(sec_done)));
endmodule

bind dfq_err_tracker dfq_err_tracker_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_err      (bus_err),
  .ctl_continue (ctl_continue),
  .ctl_reset    (ctl_reset),
  .pri_rst_done (pri_rst_done),
  .sec_done     (sec_done),
  .status       (status),
  .err_irq      (err_irq),
  .halted       (halted)
);

// File: tb/dfq_err_tracker_test.sv
module dfq_err_tracker_test;
  localparam int DEPTH = 4;
  localparam int PTR_W = 32;

  logic clk = 0, rst = 1;
  logic push_valid = 0, pop_ready = 0, sg_check_valid = 0;
  logic [PTR_W-1:0] push_ptr = '0, sg_value = '0;
  logic bus_err = 0, ctl_continue = 0, ctl_reset = 0, clr_valid = 0;
  logic [4:0] clr_mask = '0;
  logic pri_rst_done = 0, sec_rst_done = 0, pri_done = 0, sec_done = 0;
  logic pop_valid, err_irq, halted;
  logic [PTR_W-1:0] pop_ptr;
  logic [8:0] status;

  int total = 0, bad = 0, cycles = 0;
  logic [PTR_W-1:0] exp_q[$];

  always #2 clk = ~clk;

  dfq_err_tracker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // driver: the caller states whether the write is stored
  task automatic push(logic [PTR_W-1:0] p, bit stored);
    push_valid = 1; push_ptr = p;
    if (stored) exp_q.push_back(p);
    step();
    push_valid = 0;
  endtask

  task automatic drain(int n);
    pop_ready = 1;
    repeat (n) step();
    pop_ready = 0;
  endtask

  task automatic clear(logic [4:0] m);
    clr_valid = 1; clr_mask = m; step(); clr_valid = 0; clr_mask = '0;
  endtask

  // monitor: scoreboard for every pop (R2)
  always @(negedge clk) begin
    if (!rst && pop_ready && pop_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected pop", pop_ptr, 0);
      else chk("R2 order", pop_ptr, exp_q.pop_front());
    end
  end

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    chk("R1 status", status, 0);
    chk("R1 irq", err_irq, 0);
    chk("R1 halted", halted, 0);
    chk("R1 pop_valid", pop_valid, 0);

    // R2 partial fill
    push(32'h11, 1); push(32'h22, 1); push(32'h33, 1);
    drain(4);
    chk("R2 empty after drain", pop_valid, 0);

    // R3 first overflow
    for (int i = 1; i <= DEPTH; i++) push(32'hD0 + i, 1);
    push(32'hD5, 0);
    chk("R3 flag", status, 9'h001);
    chk("R10 irq on", err_irq, 1);
    chk("R3 no halt", halted, 0);
    drain(DEPTH + 1);
    chk("R3 dropped", pop_valid, 0);

    // R6 write-one-to-clear
    clear(5'b00010);
    chk("R6 zero bit keeps", status, 9'h001);
    clear(5'b00001);
    chk("R6 one bit clears", status, 0);
    chk("R10 irq off", err_irq, 0);

    // R5 full push with pop
    for (int i = 1; i <= DEPTH; i++) push(32'hE0 + i, 1);
    pop_ready = 1;
    push(32'hE5, 1);
    pop_ready = 0;
    chk("R5 no flag", status, 0);
    drain(DEPTH + 1);

    // R4 second overflow, R11 blocked, R12 continue
    for (int i = 1; i <= DEPTH; i++) push(32'hF0 + i, 1);
    push(32'hF8, 0);
    push(32'hF9, 0);
    chk("R4 both flags", status, 9'h003);
    chk("R4 halted", halted, 1);
    chk("R11 pop blocked", pop_valid, 0);
    ctl_continue = 1; step(); ctl_continue = 0;
    chk("R12 resumed", halted, 0);
    chk("R12 flags kept", status, 9'h003);
    chk("R12 contents kept", pop_valid, 1);
    drain(DEPTH + 1);
    clear(5'b00011);

    // R7 bus error, R11 push while halted
    bus_err = 1; step(); bus_err = 0;
    chk("R7 flag", status, 9'h004);
    chk("R7 halted", halted, 1);
    pop_ready = 1;
    push(32'hA1, 1);
    chk("R11 pop blocked with data", pop_valid, 0);
    pop_ready = 0;
    ctl_continue = 1; step(); ctl_continue = 0;
    drain(2);
    clear(5'b00100);

    // R8 zero pointer
    push(32'h0, 0);
    chk("R8 flag", status, 9'h008);
    chk("R8 not stored", pop_valid, 0);
    chk("R8 no halt", halted, 0);
    clear(5'b01000);

    // R9 scatter/gather zero
    sg_check_valid = 1; sg_value = 32'h40; step();
    chk("R9 nonzero ignored", status, 0);
    sg_value = 0; step(); sg_check_valid = 0;
    chk("R9 flag", status, 9'h010);
    clear(5'b10000);

    // R13 channel reset
    push(32'hB1, 1); push(32'hB2, 1);
    bus_err = 1; step(); bus_err = 0;
    ctl_reset = 1; step(); ctl_reset = 0;
    exp_q.delete();
    chk("R13 flags", status, 0);
    chk("R13 halted", halted, 0);
    chk("R13 empty", pop_valid, 0);

    // R14 mirrors
    pri_rst_done = 1; sec_done = 1; step();
    chk("R14 mirror", status, 9'h120);
    pri_rst_done = 0; step();
    chk("R14 mirror follows", status, 9'h100);

    chk("R2 scoreboard empty", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule